// File: doc/BRIEF.md
# Stuck-Clock Loss Detector

This block watches a set of clocks that are unrelated to one another and to its own clock. It flags loss of clock for each one that holds high or low for too long. Time is counted on a free-running reference clock, usually the processor clock of the chip. A monitored clock only needs to keep producing edges; its frequency is not checked.

Each monitored clock drives a toggle flop in its own domain. That toggle is brought into the reference domain through two flops. Any change seen on the synchronised toggle restarts a per-clock counter. A counter that reaches the timeout sets the loss state, and the next observed change clears it again. Each change of a loss state, in either direction, sets a sticky per-clock delta bit. Software clears delta bits by writing 1. A per-clock mask keeps a delta bit from reaching the single interrupt output.

The timeout in reference cycles is a parameter. The integrator picks it so that the resulting detection time lies strictly between 10 µs and 125 µs at the reference frequency in use. The default of 4000 cycles gives 40 µs at 100 MHz.

Top module: `clk_loss_monitor`

## Requirements
- R1: After reset, every `lost`, every `delta` bit and `irq` are 0.
- R2: A monitored clock whose half period is well under the timeout never shows loss.
- R3: A clock held low shows `lost` no earlier than TIMEOUT reference cycles and no later than TIMEOUT+6 reference cycles after its last edge.
- R4: A clock held high is detected within the same window as in R3.
- R5: When a lost clock produces edges again, its `lost` bit returns to 0 within 6 reference cycles of its first edge.
- R6: Each 0-to-1 and each 1-to-0 change of `lost[i]` sets `delta[i]` on the same clock edge.
- R7: `delta[i]` holds until a cycle in which `delta_clr[i]` is 1. A `delta_clr` bit that is 0 leaves its delta bit unchanged. A new event in the same cycle as a clear wins.
- R8: `irq` is 1 exactly when some `i` has `delta[i]`=1 and `irq_mask[i]`=0. A mask bit set to 1 blocks the interrupt from that clock and does not change `delta`.
- R9: A loss on one monitored clock does not change `lost` or `delta` for any other monitored clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference (processor) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_clk | input | NUM_CLKS | Clocks under watch |
| irq_mask | input | NUM_CLKS | 1 blocks that clock's delta from `irq` |
| delta_clr | input | NUM_CLKS | Write-1-to-clear strobe for delta bits, one reference cycle |
| lost | output | NUM_CLKS | Loss-of-clock state per monitored clock |
| delta | output | NUM_CLKS | Sticky change-of-state bits |
| irq | output | 1 | OR over all clocks of delta AND NOT mask |

## Verification
An edge on a monitored clock takes two or three reference cycles to reach the change detector. The counter then needs TIMEOUT further cycles before `lost` rises, so the bench samples once well inside that window, where it expects no loss, and once just past it, where loss must be shown. Recovery is checked 10 reference cycles after edges resume, which is later than the 6-cycle bound. `delta` and `irq` follow `lost` and `delta_clr` with one register and no register respectively, so they are sampled on the falling reference edge after the cause. The bench uses a short timeout to keep runs brief.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  // Width of a counter able to hold values 0..max_val
  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/clkmon_toggle.sv
module clkmon_toggle (
  input  logic clk_in,
  input  logic rst_n,
  output logic tgl
);
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end
endmodule

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic async_in,
  output logic seen_change
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign seen_change = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/clkmon_timer.sv
module clkmon_timer #(
  parameter int TIMEOUT = 4000
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic seen_change,
  output logic lost,
  output logic evt
);
  localparam int CW = clkmon_pkg::cnt_width(TIMEOUT);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;
  logic          go_lost;
  logic          go_ok;

  assign go_lost = !seen_change && !lost && (cnt == LIMIT);
  assign go_ok   = seen_change && lost;
  assign evt     = go_lost || go_ok;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      lost <= 1'b0;
    end else if (seen_change) begin
      cnt  <= '0;
      lost <= 1'b0;
    end else begin
      if (cnt != LIMIT) cnt <= cnt + 1'b1;
      if (go_lost)      lost <= 1'b1;
    end
  end

  // An observed edge always leaves the clock in the good state
  assert_edge_clears_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    seen_change |=> !lost);
  // Loss cannot appear in the cycle right after an edge was seen
  assert_no_early_loss_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (seen_change && !lost) |=> !$rose(lost));
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
  parameter int NUM_CLKS = 3,
  // Reference cycles without an edge before loss; pick for 10us < T < 125us
  parameter int TIMEOUT  = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                ref_clk,
  input  logic                rst_n,
  input  logic [NUM_CLKS-1:0] mon_clk,
  input  logic [NUM_CLKS-1:0] irq_mask,
  input  logic [NUM_CLKS-1:0] delta_clr,
  output logic [NUM_CLKS-1:0] lost,
  output logic [NUM_CLKS-1:0] delta,
  output logic                irq
);
  logic [NUM_CLKS-1:0] tgl;
  logic [NUM_CLKS-1:0] chg;
  logic [NUM_CLKS-1:0] evt;

  for (genvar g = 0; g < NUM_CLKS; g++) begin : g_chan
    clkmon_toggle u_tgl (
      .clk_in (mon_clk[g]),
      .rst_n  (rst_n),
      .tgl    (tgl[g])
    );
    clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .ref_clk     (ref_clk),
      .rst_n       (rst_n),
      .async_in    (tgl[g]),
      .seen_change (chg[g])
    );
    clkmon_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
      .ref_clk     (ref_clk),
      .rst_n       (rst_n),
      .seen_change (chg[g]),
      .lost        (lost[g]),
      .evt         (evt[g])
    );

    assert_delta_on_change_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (lost[g] != $past(lost[g])) |-> delta[g]);
    assert_delta_sticky_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (delta[g] && !delta_clr[g]) |=> delta[g]);
    assert_masked_quiet_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (delta[g] && !irq_mask[g]) |-> irq);
  end

  // Sticky change bits; a fresh event overrides a clear in the same cycle
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) delta <= '0;
    else        delta <= (delta & ~delta_clr) | evt;
  end

  assign irq = |(delta & ~irq_mask);

  assert_all_masked_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (&irq_mask) |-> !irq);
endmodule

// File: tb/clk_loss_monitor_test.sv
`timescale 1ns/1ps
module clk_loss_monitor_test;
  localparam int N  = 3;
  localparam int TO = 64;

  logic ref_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic [N-1:0] mclk = '0;
  logic [N-1:0] run  = '0;
  logic [N-1:0] irq_mask  = '0;
  logic [N-1:0] delta_clr = '0;
  logic [N-1:0] lost, delta;
  logic irq;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 ref_clk = ~ref_clk;

  // Monitored clocks with unrelated periods
  always begin if (run[0]) begin #3.5;  if (run[0]) mclk[0] = ~mclk[0]; end else #0.5; end
  always begin if (run[1]) begin #6.5;  if (run[1]) mclk[1] = ~mclk[1]; end else #0.5; end
  always begin if (run[2]) begin #11.5; if (run[2]) mclk[2] = ~mclk[2]; end else #0.5; end

  clk_loss_monitor #(.NUM_CLKS(N), .TIMEOUT(TO)) uut (
    .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mclk), .irq_mask(irq_mask),
    .delta_clr(delta_clr), .lost(lost), .delta(delta), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic clr_pulse(input logic [N-1:0] m);
    delta_clr = m;
    cyc(1);
    delta_clr = '0;
    cyc(1);
  endtask

  task automatic t_reset();
    cyc(1);
    chk("R1 lost", 32'(lost), 0);
    chk("R1 delta", 32'(delta), 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_running();
    logic [N-1:0] seen = '0;
    for (int k = 0; k < 300; k++) begin cyc(1); seen |= lost; end
    chk("R2 no loss while running", 32'(seen), 0);
    chk("R2 no delta while running", 32'(delta), 0);
  endtask

  task automatic t_stuck(input int i, input logic lvl, input string req);
    run[i] = 1'b0;
    mclk[i] = lvl;
    cyc(TO - 10);
    chk({req, " not before timeout"}, 32'(lost[i]), 0);
    cyc(20);
    chk({req, " lost after timeout"}, 32'(lost[i]), 1);
    chk("R9 other clocks unaffected", 32'(lost & ~(N'(1) << i)), 0);
    chk("R9 other deltas unaffected", 32'(delta & ~(N'(1) << i)), 0);
    chk("R6 delta on loss", 32'(delta[i]), 1);
    chk("R8 irq unmasked", 32'(irq), 1);
  endtask

  task automatic t_mask_clear(input int i);
    irq_mask = N'(1) << i;
    cyc(1);
    chk("R8 irq masked", 32'(irq), 0);
    chk("R8 mask keeps delta", 32'(delta[i]), 1);
    irq_mask = '0;
    clr_pulse(~(N'(1) << i));
    chk("R7 other clear bits no effect", 32'(delta[i]), 1);
    clr_pulse(N'(1) << i);
    chk("R7 write-1 clears", 32'(delta[i]), 0);
    chk("R8 irq drops with delta", 32'(irq), 0);
    cyc(20);
    chk("R7 stays clear while lost holds", 32'(delta[i]), 0);
  endtask

  task automatic t_recover(input int i);
    run[i] = 1'b1;
    cyc(10);
    chk("R5 loss clears", 32'(lost[i]), 0);
    chk("R6 delta on clearing", 32'(delta[i]), 1);
    clr_pulse(N'(1) << i);
    chk("R7 clear after recovery", 32'(delta), 0);
  endtask

  initial begin
    run = '1;
    cyc(4);
    rst_n = 1'b1;
    t_reset();
    t_running();
    t_stuck(0, 1'b0, "R3");
    t_mask_clear(0);
    t_recover(0);
    t_stuck(2, 1'b1, "R4");
    t_mask_clear(2);
    t_recover(2);
    t_running();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule